// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through cache and a slow main memory. The processor's store port posts an address, a data word and a byte-enable mask into a small first-in first-out queue. A store counts as complete on the cycle the queue takes it, so the processor goes on without waiting for memory. A drain path presents the oldest entry to memory over a valid/ready handshake and keeps it there until memory takes it, which may be many cycles later.

When the queue holds its full number of entries and memory is not taking one, the store port drops its ready signal and the processor stalls. Stores offered faster than one per memory write cycle fill the queue whatever its depth, and the stall then lasts. Full, empty and occupancy outputs make that saturation visible. A cache controller can watch the empty flag and hold back a read-miss fill until every posted store has reached memory.

Top module: `wt_store_buf`

## Requirements
- R1: After reset the block shows empty_o=1, full_o=0, count_o=0, mem_valid_o=0 and st_ready_o=1.
- R2: A store accepted into an empty buffer appears on mem_addr_o, mem_data_o and mem_mask_o, with mem_valid_o=1, in the cycle after the accepting clock edge.
- R3: Stores reach memory in the order they were accepted, with address, data and mask unchanged.
- R4: An entry is removed only on a clock edge where mem_valid_o and mem_ready_i are both 1. While mem_ready_i is 0, mem_valid_o and the memory outputs hold steady.
- R5: With DEPTH (default 4) entries held, full_o=1, and st_ready_o=0 whenever mem_ready_i=0.
- R6: When the buffer is full and mem_ready_i=1, st_ready_o=1. A store offered in that cycle is accepted while the head drains, and count_o stays at DEPTH.
- R7: count_o equals accepted stores minus drained stores. full_o=1 exactly when count_o=DEPTH, and empty_o=1 exactly when count_o=0.
- R8: With stores offered every cycle and memory taking one only every few cycles, the buffer reaches full and the store port stalls for a sustained number of cycles, yet no store is lost.
- R9: A store offered while st_ready_o=0 has no effect. It is never written to the buffer and never reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | Processor offers a store |
| st_ready_o | output | 1 | Buffer accepts the offered store this cycle |
| st_addr_i | input | 32 | Store address |
| st_data_i | input | 32 | Store data |
| st_mask_i | input | 4 | Store byte enables |
| mem_valid_o | output | 1 | Head entry is presented to memory |
| mem_ready_i | input | 1 | Memory takes the head entry this cycle |
| mem_addr_o | output | 32 | Head entry address |
| mem_data_o | output | 32 | Head entry data |
| mem_mask_o | output | 4 | Head entry byte enables |
| full_o | output | 1 | Buffer holds DEPTH entries |
| empty_o | output | 1 | Buffer holds no entries |
| count_o | output | 3 | Number of entries held |

## Verification
The hardest case to reach is the cycle in which the buffer is full, memory takes the head, and a new store arrives in the same cycle. A push and a pop must then both happen and leave the count at DEPTH. The bench gets there by holding memory off while it fills the buffer from its vector table, and then raising mem_ready_i together with a new store in one cycle. A second phase pairs a memory model with a fixed multi-cycle write time against stores offered every cycle. This drives the buffer into sustained saturation, and the bench counts the stall cycles and checks that every store arrives in order.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;
  parameter int MASK_W = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [MASK_W-1:0] mask;
  } wsb_entry_t;
endpackage

// File: rtl/wsb_ctrl.sv
module wsb_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      count_o  <= '0;
    end else begin
      if (push_i) wr_ptr_o <= (wr_ptr_o == LAST_PTR) ? '0 : wr_ptr_o + 1'b1;
      if (pop_i)  rd_ptr_o <= (rd_ptr_o == LAST_PTR) ? '0 : rd_ptr_o + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT); // R7
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (count_o == $past(count_o) + 1'b1)); // R7
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (count_o == $past(count_o) - 1'b1)); // R7
endmodule

// File: rtl/wsb_store.sv
module wsb_store
  import wsb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  wsb_entry_t       wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output wsb_entry_t       rdata_o
);
  wsb_entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[g] <= '0;
      else if (we_i && (waddr_i == PTR_W'(g)))     slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/wt_store_buf.sv
module wt_store_buf
  import wsb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [MASK_W-1:0] st_mask_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [MASK_W-1:0] mem_mask_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             push, pop;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  wsb_entry_t       in_ent, head_ent;

  assign full_o      = (count_o == FULL_CNT);
  assign empty_o     = (count_o == '0);
  assign mem_valid_o = !empty_o;
  // a pop frees a slot in the same cycle, so full does not block
  assign st_ready_o  = !full_o || mem_ready_i;
  assign push        = st_valid_i && st_ready_o;
  assign pop         = mem_valid_o && mem_ready_i;

  assign in_ent = '{addr: st_addr_i, data: st_data_i, mask: st_mask_i};

  wsb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .count_o  (count_o)
  );

  wsb_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push),
    .waddr_i (wr_ptr),
    .wdata_i (in_ent),
    .raddr_i (rd_ptr),
    .rdata_o (head_ent)
  );

  assign mem_addr_o = head_ent.addr;
  assign mem_data_o = head_ent.data;
  assign mem_mask_o = head_ent.mask;

  AST_FIRST_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && empty_o) |=> (mem_valid_o && mem_addr_o == $past(st_addr_i)
                           && mem_data_o == $past(st_data_i)
                           && mem_mask_o == $past(st_mask_i))); // R2
  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
                                       && $stable(mem_data_o) && $stable(mem_mask_o))); // R4
  AST_FULL_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !mem_ready_i) |=> (full_o && $stable(count_o))); // R5
  AST_FULL_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && st_valid_i && mem_ready_i) |=> (count_o == FULL_CNT)); // R6
endmodule

// File: tb/wt_store_buf_tb.sv
module wt_store_buf_tb;
  localparam int DEPTH  = 4;
  localparam int WR_CYC = 4;
  localparam int N_SAT  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [3:0]  st_mask = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_mask;
  logic        full, empty;
  logic [2:0]  count;

  always #5 clk = ~clk;

  wt_store_buf #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready),
    .st_addr_i(st_addr), .st_data_i(st_data), .st_mask_i(st_mask),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_mask_o(mem_mask),
    .full_o(full), .empty_o(empty), .count_o(count)
  );

  // {addr, data, mask}
  localparam logic [67:0] VEC [0:4] = '{
    {32'h0000_1000, 32'hDEAD_0001, 4'hF},
    {32'h0000_1004, 32'h1234_5678, 4'h3},
    {32'h0000_2008, 32'hCAFE_F00D, 4'hC},
    {32'h8000_000C, 32'h0BAD_BEEF, 4'h1},
    {32'h0000_3010, 32'hA5A5_5A5A, 4'h8}
  };

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [67:0] log_q [0:63];
  int n_log = 0;
  bit mem_en = 1'b0;
  int wait_cnt = 0;
  int stalls = 0;
  int max_cnt = 0;

  // memory model: takes one entry after WR_CYC cycles of presentation
  always @(negedge clk) begin
    if (mem_en) begin
      if (mem_ready) begin
        mem_ready = 1'b0;
        wait_cnt  = 0;
      end else if (mem_valid) begin
        if (wait_cnt >= WR_CYC - 1) begin
          mem_ready = 1'b1;
          log_q[n_log] = {mem_addr, mem_data, mem_mask};
          n_log++;
        end else wait_cnt++;
      end
    end
  end

  always @(negedge clk) if (int'(count) > max_cnt) max_cnt = int'(count);

  task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [67:0] v);
    @(negedge clk);
    st_valid = 1'b1;
    {st_addr, st_data, st_mask} = v;
    #1;
    while (!st_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 st_valid = 1'b0;
  endtask

  task automatic drain_wait();
    while (!empty) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [67:0] sat_vec(input int i);
    return {32'h4000_0000 + 32'(i * 4), 32'h5000_0000 ^ 32'(i * 32'h0101_0101), 4'(i + 1)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 empty", 68'(empty), 68'(1));
    check("R1 full", 68'(full), 68'(0));
    check("R1 count", 68'(count), 68'(0));
    check("R1 mem_valid", 68'(mem_valid), 68'(0));
    #1 check("R1 st_ready", 68'(st_ready), 68'(1));
    rst_n = 1'b1;

    // fill from table with memory held off
    for (int i = 0; i < DEPTH; i++) begin
      push(VEC[i]);
      @(negedge clk);
      check("R7 count", 68'(count), 68'(i + 1));
      if (i == 0) check("R2 head", {mem_addr, mem_data, mem_mask}, VEC[0]);
    end
    check("R5 full", 68'(full), 68'(1));
    #1 check("R5 st_ready low", 68'(st_ready), 68'(0));

    // R4 hold while not ready; R9 offered store ignored
    @(negedge clk);
    st_valid = 1'b1;
    {st_addr, st_data, st_mask} = {32'hFFFF_FFF0, 32'hBAD0_BAD0, 4'h5};
    repeat (3) @(negedge clk);
    check("R4 hold", {mem_valid, mem_addr, mem_data, mem_mask}, {1'b1, VEC[0]});
    check("R9 count", 68'(count), 68'(DEPTH));
    st_valid = 1'b0;

    // R6 push and pop in the same cycle while full
    @(negedge clk);
    mem_ready = 1'b1;
    st_valid = 1'b1;
    {st_addr, st_data, st_mask} = VEC[4];
    #1 check("R6 st_ready", 68'(st_ready), 68'(1));
    @(posedge clk);
    #1;
    mem_ready = 1'b0;
    st_valid = 1'b0;
    @(negedge clk);
    check("R6 count", 68'(count), 68'(DEPTH));
    check("R6 head", {mem_addr, mem_data, mem_mask}, VEC[1]);

    // drain: R3 order, R9 bogus store absent
    mem_en = 1'b1;
    drain_wait();
    check("R9 drained", 68'(n_log), 68'(4));
    for (int i = 0; i < 4; i++) check("R3 order", log_q[i], VEC[i + 1]);
    check("R7 empty", 68'({empty, full, count}), 68'({1'b1, 1'b0, 3'd0}));

    // R8 saturation
    n_log = 0;
    stalls = 0;
    max_cnt = 0;
    for (int i = 0; i < N_SAT; i++) push(sat_vec(i));
    check("R8 reached full", 68'(max_cnt), 68'(DEPTH));
    n_chk++;
    if (stalls < 30) begin
      n_bad++;
      $display("FAIL R8 stalls: actual %0d expected >= 30", stalls);
    end
    drain_wait();
    check("R8 none lost", 68'(n_log), 68'(N_SAT));
    for (int i = 0; i < N_SAT; i++) check("R3 sat order", log_q[i], sat_vec(i));
    check("R7 empty end", 68'(empty), 68'(1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule